// File: doc/BRIEF.md
# Link Integrity, Jabber and Heartbeat Controller

This block supervises one 10BASE-T twisted-pair port. It watches the receive side for link pulses and packet activity. It declares the link good or failed, and it corrects a receive pair that is wired the wrong way round once enough reversed link pulses have been seen. On the transmit side it emits idle link pulses at a fixed interval, cuts off a transmitter that stays on too long, and produces the short heartbeat pulse that follows each transmission.

Collision, heartbeat and jabber all drive a single collision output toward the MAC. The block also picks between the twisted-pair media and the alternate attachment-unit media when the port is set to auto-select. Two enables are sampled from strap pins while reset is held: one for link testing and one for heartbeat.

The block works purely in clock cycles. Every time interval is a parameter, and the defaults assume a 10 MHz clock. Analog squelch and pulse shaping sit outside the block.

Top module: `link_sup`

## Requirements
- R1: The link-test and heartbeat strap inputs are captured only while rst_ni is low. Changing them after reset release has no effect on link_ok_o or on heartbeat.
- R2: With link testing strapped off, link_ok_o is held at 1 even if no pulses arrive. Link pulses are still emitted on lp_tx_o.
- R3: While txe_i is low, lp_tx_o gives a one-cycle strobe every LP_PERIOD_CYC cycles. The first strobe comes LP_PERIOD_CYC cycles after reset release or after txe_i falls. No strobe appears while txe_i is high, and raising txe_i restarts the interval.
- R4: The link state is failed after reset. A passing link fails once LINK_FAIL_CYC cycles pass with no received pulse and no receive activity. A failed link passes again after RECOV_PULSES pulses, each arriving less than LINK_FAIL_CYC cycles after the one before. A pulse after a longer gap restarts that count at one.
- R5: A received pulse is reversed when lp_rev_i differs from pol_inv_o. After POL_PULSES consecutive reversed pulses, pol_inv_o toggles. A non-reversed pulse clears the count, and pol_inv_o changes only on a pulse.
- R6: When txe_i has been high for JAB_CYC consecutive cycles, tx_block_o and col_o go high.
- R7: The jabber lockout releases after UNJAB_CYC consecutive cycles with txe_i low. Any cycle with txe_i high restarts that wait.
- R8: With heartbeat strapped on and no jabber at the falling edge of txe_i, col_o goes high for HB_LEN_CYC cycles. It starts HB_DLY_CYC cycles after the cycle in which txe_i is first seen low. If txe_i rises during the delay, the pulse is cancelled. A fall during jabber gives no heartbeat.
- R9: A collision (txe_i and rx_act_i both high) raises col_o after COL_ON_CYC cycles and clears it COL_OFF_CYC cycles after either input drops. Collision is not reported in effective full duplex, but heartbeat still is.
- R10: media_mode_i selects the media. 2'b00 selects the alternate media, 2'b01 selects twisted pair, and 2'b1x auto-selects twisted pair exactly when link_ok_o is 1. fdx_o = fdx_i & utp_sel_o, and loop_en_o = utp_sel_o & ~fdx_o.
- R11: col_o is the OR of the filtered collision, the heartbeat pulse and the jabber lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; straps are captured while low |
| lt_strap_i | input | 1 | Link-test enable strap |
| hb_strap_i | input | 1 | Heartbeat enable strap |
| media_mode_i | input | 2 | 00 alternate media, 01 twisted pair, 1x auto-select |
| fdx_i | input | 1 | Full-duplex request |
| txe_i | input | 1 | Transmit enable from the MAC |
| rx_act_i | input | 1 | Receive packet activity |
| lp_i | input | 1 | One-cycle strobe: a link pulse was received |
| lp_rev_i | input | 1 | Raw polarity of the received pulse (1 = negative) |
| link_ok_o | output | 1 | Link passing |
| pol_inv_o | output | 1 | Receive polarity correction active |
| lp_tx_o | output | 1 | One-cycle strobe: emit a link pulse |
| tx_block_o | output | 1 | Transmit inhibited by jabber |
| col_o | output | 1 | Collision / heartbeat / jabber indication |
| utp_sel_o | output | 1 | Twisted-pair media selected |
| fdx_o | output | 1 | Effective full duplex |
| loop_en_o | output | 1 | Internal transmit-to-receive loopback enabled |

## Verification
The collision filter's release delay and the heartbeat delay both start when txe_i falls, and both drive col_o. The bench makes them meet by holding rx_act_i high while a colliding transmission ends. It then checks col_o cycle by cycle: the collision release comes first, then a gap, then the heartbeat window. The same window is also checked with full duplex on. There, collision must stay silent while heartbeat still appears, and a jabber-ended transmission must produce no heartbeat at all.

// File: rtl/link_sup_pkg.sv
package link_sup_pkg;
  typedef enum logic [1:0] {HB_IDLE, HB_WAIT, HB_PULSE} hb_state_e;
  localparam logic [1:0] MEDIA_UTP = 2'b01;
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lnk_mon.sv
module lnk_mon #(
  parameter int LINK_FAIL_CYC = 1000000,
  parameter int RECOV_PULSES  = 2,
  parameter int POL_PULSES    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_act_i,
  input  logic lp_i,
  input  logic lp_rev_i,
  output logic pass_o,
  output logic pol_inv_o
);
  localparam int GW = $clog2(LINK_FAIL_CYC + 1);
  localparam int RW = $clog2(RECOV_PULSES + 1);
  localparam int PW = $clog2(POL_PULSES + 1);
  localparam logic [GW-1:0] GAP_MAX  = GW'(LINK_FAIL_CYC);
  localparam logic [GW-1:0] GAP_LAST = GW'(LINK_FAIL_CYC - 1);
  localparam logic [RW-1:0] RC_LAST  = RW'(RECOV_PULSES - 1);
  localparam logic [RW-1:0] RC_ONE   = RW'(1);
  localparam logic [PW-1:0] PC_LAST  = PW'(POL_PULSES - 1);

  logic [GW-1:0] gap_q;
  logic [RW-1:0] rc_q;
  logic [PW-1:0] pc_q;
  logic pass_q, pol_q, act, in_win;

  // packets keep a passing link alive; only pulses revive a failed one
  assign act    = lp_i | (pass_q & rx_act_i);
  assign in_win = (gap_q != GAP_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= GAP_MAX;
      pass_q <= 1'b0;
      rc_q   <= '0;
    end else begin
      if (act)             gap_q <= '0;
      else if (in_win)     gap_q <= gap_q + 1'b1;
      if (pass_q) begin
        rc_q <= '0;
        if (!act && gap_q == GAP_LAST) pass_q <= 1'b0;
      end else if (lp_i) begin
        if (in_win && rc_q == RC_LAST) begin
          pass_q <= 1'b1;
          rc_q   <= '0;
        end else if (in_win) begin
          rc_q <= rc_q + 1'b1;
        end else begin
          rc_q <= RC_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q <= 1'b0;
      pc_q  <= '0;
    end else if (lp_i) begin
      if (lp_rev_i != pol_q) begin
        if (pc_q == PC_LAST) begin
          pol_q <= ~pol_q;
          pc_q  <= '0;
        end else begin
          pc_q <= pc_q + 1'b1;
        end
      end else begin
        pc_q <= '0;
      end
    end
  end

  assign pass_o    = pass_q;
  assign pol_inv_o = pol_q;

  a_r5_pol_only_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lp_i |=> $stable(pol_q));
  a_r4_fail_after_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pass_q) |-> (gap_q == GAP_MAX));
  a_r4_pass_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_q) |-> $past(lp_i));
endmodule

// File: rtl/lp_gen.sv
module lp_gen #(
  parameter int LP_PERIOD_CYC = 160000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txe_i,
  output logic lp_tx_o
);
  localparam int LW = $clog2(LP_PERIOD_CYC);
  localparam logic [LW-1:0] LP_LAST = LW'(LP_PERIOD_CYC - 1);

  logic [LW-1:0] cnt_q;
  logic lp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lp_q  <= 1'b0;
    end else if (txe_i) begin
      cnt_q <= '0;
      lp_q  <= 1'b0;
    end else if (cnt_q == LP_LAST) begin
      cnt_q <= '0;
      lp_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      lp_q  <= 1'b0;
    end
  end

  assign lp_tx_o = lp_q;

  a_r3_quiet_in_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txe_i |=> !lp_q);
endmodule

// File: rtl/jab_hb.sv
module jab_hb
  import link_sup_pkg::*;
#(
  parameter int JAB_CYC    = 450000,
  parameter int UNJAB_CYC  = 5000000,
  parameter int HB_DLY_CYC = 10,
  parameter int HB_LEN_CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txe_i,
  input  logic hb_en_i,
  output logic jab_o,
  output logic hb_o
);
  localparam int JW = $clog2(JAB_CYC + 1);
  localparam int UW = $clog2(UNJAB_CYC);
  localparam int HW = $clog2(max2(HB_DLY_CYC, HB_LEN_CYC) + 1);
  localparam logic [JW-1:0] JAB_MAX  = JW'(JAB_CYC);
  localparam logic [JW-1:0] JAB_LAST = JW'(JAB_CYC - 1);
  localparam logic [UW-1:0] UJ_LAST  = UW'(UNJAB_CYC - 1);
  localparam logic [HW-1:0] DLY_LAST = HW'(HB_DLY_CYC - 1);
  localparam logic [HW-1:0] LEN_LAST = HW'(HB_LEN_CYC - 1);

  logic [JW-1:0] tx_cnt_q;
  logic [UW-1:0] uj_q;
  logic [HW-1:0] hc_q;
  logic jab_q, txe_d_q, tx_fall, hb_q;
  hb_state_e st_q;

  assign tx_fall = txe_d_q & ~txe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_cnt_q <= '0;
      uj_q     <= '0;
      jab_q    <= 1'b0;
      txe_d_q  <= 1'b0;
    end else begin
      txe_d_q <= txe_i;
      if (!txe_i)                            tx_cnt_q <= '0;
      else if (!jab_q && tx_cnt_q != JAB_MAX) tx_cnt_q <= tx_cnt_q + 1'b1;
      if (!jab_q) begin
        uj_q <= '0;
        if (txe_i && tx_cnt_q == JAB_LAST) jab_q <= 1'b1;
      end else if (txe_i) begin
        uj_q <= '0;
      end else if (uj_q == UJ_LAST) begin
        jab_q <= 1'b0;
        uj_q  <= '0;
      end else begin
        uj_q <= uj_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= HB_IDLE;
      hc_q <= '0;
    end else begin
      case (st_q)
        HB_IDLE: if (tx_fall && hb_en_i && !jab_q) begin
          st_q <= HB_WAIT;
          hc_q <= '0;
        end
        HB_WAIT: begin
          if (txe_i) begin
            st_q <= HB_IDLE;  // new transmission cancels pending heartbeat
            hc_q <= '0;
          end else if (hc_q == DLY_LAST) begin
            st_q <= HB_PULSE;
            hc_q <= '0;
          end else begin
            hc_q <= hc_q + 1'b1;
          end
        end
        HB_PULSE: begin
          if (hc_q == LEN_LAST) begin
            st_q <= HB_IDLE;
            hc_q <= '0;
          end else begin
            hc_q <= hc_q + 1'b1;
          end
        end
        default: begin
          st_q <= HB_IDLE;
          hc_q <= '0;
        end
      endcase
    end
  end

  assign hb_q  = (st_q == HB_PULSE);
  assign jab_o = jab_q;
  assign hb_o  = hb_q;

  a_r6_jab_needs_txe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jab_q) |-> $past(txe_i));
  a_r7_release_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(jab_q) |-> !$past(txe_i));
  a_r8_pulse_after_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hb_q) |-> !$past(txe_i));
endmodule

// File: rtl/col_filt.sv
module col_filt
  import link_sup_pkg::*;
#(
  parameter int COL_ON_CYC  = 3,
  parameter int COL_OFF_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txe_i,
  input  logic rx_i,
  input  logic en_i,
  output logic col_o
);
  localparam int CW = $clog2(max2(COL_ON_CYC, COL_OFF_CYC) + 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(COL_ON_CYC - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(COL_OFF_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic col_q, both;

  assign both = txe_i & rx_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= 1'b0;
      cnt_q <= '0;
    end else if (col_q != both) begin
      if (cnt_q == (both ? ON_LAST : OFF_LAST)) begin
        col_q <= both;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign col_o = col_q;

  a_r9_rise_needs_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(col_q) |-> $past(both));
  a_r9_fall_needs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(col_q) |-> !$past(both));
endmodule

// File: rtl/link_sup.sv
module link_sup
  import link_sup_pkg::*;
#(
  parameter int LINK_FAIL_CYC = 1000000,
  parameter int RECOV_PULSES  = 2,
  parameter int POL_PULSES    = 8,
  parameter int LP_PERIOD_CYC = 160000,
  parameter int JAB_CYC       = 450000,
  parameter int UNJAB_CYC     = 5000000,
  parameter int HB_DLY_CYC    = 10,
  parameter int HB_LEN_CYC    = 10,
  parameter int COL_ON_CYC    = 3,
  parameter int COL_OFF_CYC   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lt_strap_i,
  input  logic       hb_strap_i,
  input  logic [1:0] media_mode_i,
  input  logic       fdx_i,
  input  logic       txe_i,
  input  logic       rx_act_i,
  input  logic       lp_i,
  input  logic       lp_rev_i,
  output logic       link_ok_o,
  output logic       pol_inv_o,
  output logic       lp_tx_o,
  output logic       tx_block_o,
  output logic       col_o,
  output logic       utp_sel_o,
  output logic       fdx_o,
  output logic       loop_en_o
);
  logic lt_en_q, hb_en_q;
  logic pass, link_ok, utp_sel, fdx_eff;
  logic jab, hb, col_raw;

  // straps track the pins while reset is held, then freeze
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lt_en_q <= lt_strap_i;
      hb_en_q <= hb_strap_i;
    end
  end

  lnk_mon #(
    .LINK_FAIL_CYC(LINK_FAIL_CYC),
    .RECOV_PULSES (RECOV_PULSES),
    .POL_PULSES   (POL_PULSES)
  ) u_lnk_mon (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_act_i (rx_act_i),
    .lp_i     (lp_i),
    .lp_rev_i (lp_rev_i),
    .pass_o   (pass),
    .pol_inv_o(pol_inv_o)
  );

  lp_gen #(.LP_PERIOD_CYC(LP_PERIOD_CYC)) u_lp_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .txe_i  (txe_i),
    .lp_tx_o(lp_tx_o)
  );

  jab_hb #(
    .JAB_CYC   (JAB_CYC),
    .UNJAB_CYC (UNJAB_CYC),
    .HB_DLY_CYC(HB_DLY_CYC),
    .HB_LEN_CYC(HB_LEN_CYC)
  ) u_jab_hb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .txe_i  (txe_i),
    .hb_en_i(hb_en_q),
    .jab_o  (jab),
    .hb_o   (hb)
  );

  assign link_ok = pass | ~lt_en_q;
  assign utp_sel = (media_mode_i == MEDIA_UTP) | (media_mode_i[1] & link_ok);
  assign fdx_eff = fdx_i & utp_sel;

  col_filt #(
    .COL_ON_CYC (COL_ON_CYC),
    .COL_OFF_CYC(COL_OFF_CYC)
  ) u_col_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .txe_i (txe_i),
    .rx_i  (rx_act_i),
    .en_i  (~fdx_eff),
    .col_o (col_raw)
  );

  assign link_ok_o  = link_ok;
  assign utp_sel_o  = utp_sel;
  assign fdx_o      = fdx_eff;
  assign loop_en_o  = utp_sel & ~fdx_eff;
  assign tx_block_o = jab;
  assign col_o      = col_raw | hb | jab;

  a_r6_block_shows_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_block_o |-> col_o);
  a_r10_fdx_on_utp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fdx_o |-> !loop_en_o);
endmodule

// File: tb/link_sup_bench.sv
module link_sup_bench;
  localparam int LF = 40, RC = 2, PP = 8, LP = 20, JB = 60, UJ = 50;
  localparam int HD = 4, HL = 3, CON = 3, COFF = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni, lt_strap_i, hb_strap_i, fdx_i, txe_i, rx_act_i, lp_i, lp_rev_i;
  logic [1:0] media_mode_i;
  logic link_ok_o, pol_inv_o, lp_tx_o, tx_block_o, col_o, utp_sel_o, fdx_o, loop_en_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  link_sup #(
    .LINK_FAIL_CYC(LF), .RECOV_PULSES(RC), .POL_PULSES(PP), .LP_PERIOD_CYC(LP),
    .JAB_CYC(JB), .UNJAB_CYC(UJ), .HB_DLY_CYC(HD), .HB_LEN_CYC(HL),
    .COL_ON_CYC(CON), .COL_OFF_CYC(COFF)
  ) u_link_sup (
    .clk_i(clk), .rst_ni(rst_ni), .lt_strap_i(lt_strap_i), .hb_strap_i(hb_strap_i),
    .media_mode_i(media_mode_i), .fdx_i(fdx_i), .txe_i(txe_i), .rx_act_i(rx_act_i),
    .lp_i(lp_i), .lp_rev_i(lp_rev_i), .link_ok_o(link_ok_o), .pol_inv_o(pol_inv_o),
    .lp_tx_o(lp_tx_o), .tx_block_o(tx_block_o), .col_o(col_o), .utp_sel_o(utp_sel_o),
    .fdx_o(fdx_o), .loop_en_o(loop_en_o)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int hb_exp(input int k);
    return (k >= HD + 1 && k <= HD + HL) ? 1 : 0;
  endfunction

  task automatic pulse(input bit rev);
    lp_i = 1'b1;
    lp_rev_i = rev;
    tick();
    lp_i = 1'b0;
    lp_rev_i = 1'b0;
  endtask

  task automatic do_reset(input bit lt, input bit hb);
    rst_ni = 1'b0;
    lt_strap_i = lt;
    hb_strap_i = hb;
    tick(3);
    rst_ni = 1'b1;
    lt_strap_i = ~lt;
    hb_strap_i = ~hb;
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int exp_pol, pcnt, any;
    void'($urandom(32'h1a2b3c));
    fdx_i = 0; txe_i = 0; rx_act_i = 0; lp_i = 0; lp_rev_i = 0;
    media_mode_i = 2'b10;
    do_reset(1'b1, 1'b1);

    // reset state
    chk("R4", "link_ok after reset", link_ok_o, 0);
    chk("R5", "pol_inv after reset", pol_inv_o, 0);
    chk("R6", "tx_block after reset", tx_block_o, 0);
    chk("R11", "col after reset", col_o, 0);
    chk("R10", "utp_sel auto with failed link", utp_sel_o, 0);
    chk("R10", "loop_en on alternate media", loop_en_o, 0);

    // R4 recovery
    pulse(0);
    chk("R4", "one pulse not enough", link_ok_o, 0);
    tick(5);
    pulse(0);
    chk("R4", "link passes after two pulses", link_ok_o, 1);
    chk("R10", "auto selects twisted pair", utp_sel_o, 1);
    chk("R10", "loopback in half duplex", loop_en_o, 1);
    chk("R10", "fdx_o off", fdx_o, 0);
    tick(LF - 1);
    chk("R4", "link held one cycle before timeout", link_ok_o, 1);
    tick();
    chk("R4", "link fails at timeout", link_ok_o, 0);
    chk("R10", "auto falls back to alternate media", utp_sel_o, 0);

    // R4 gap too long restarts count
    pulse(0);
    tick(LF + 5);
    pulse(0);
    chk("R4", "late pulse restarts count", link_ok_o, 0);
    tick(3);
    pulse(0);
    chk("R4", "timely pulse restores link", link_ok_o, 1);

    // R4 receive activity keeps link
    rx_act_i = 1;
    tick(LF + 20);
    chk("R4", "activity keeps link", link_ok_o, 1);
    rx_act_i = 0;
    tick(LF - 1);
    chk("R4", "link before timeout after activity", link_ok_o, 1);
    tick();
    chk("R4", "link fails after activity stops", link_ok_o, 0);
    pulse(0); tick(2); pulse(0);
    chk("R4", "link back", link_ok_o, 1);

    // R5 directed
    for (int i = 0; i < PP - 1; i++) begin pulse(1); tick(); end
    chk("R5", "no toggle at 7 reversed", pol_inv_o, 0);
    pulse(0); tick();
    for (int i = 0; i < PP - 1; i++) begin pulse(1); tick(); end
    chk("R5", "normal pulse cleared count", pol_inv_o, 0);
    pulse(1);
    chk("R5", "toggle at 8th reversed", pol_inv_o, 1);
    for (int i = 0; i < PP; i++) begin pulse(0); tick(); end
    chk("R5", "toggle back on reversed relative to correction", pol_inv_o, 0);

    // R5 random
    exp_pol = 0;
    pcnt = 0;
    for (int i = 0; i < 150; i++) begin
      bit rv;
      rv = (($urandom % 4) != 0);
      pulse(bit'(exp_pol) ^ rv);
      if (rv) begin
        if (pcnt == PP - 1) begin exp_pol ^= 1; pcnt = 0; end
        else pcnt++;
      end else pcnt = 0;
      chk("R5", "random polarity tracking", pol_inv_o, exp_pol);
    end
    chk("R4", "link kept by pulses", link_ok_o, 1);

    // R9 collision, half duplex
    rx_act_i = 1; txe_i = 1;
    tick(CON - 1);
    chk("R9", "collision not yet", col_o, 0);
    tick();
    chk("R9", "collision reported", col_o, 1);
    rx_act_i = 0;
    tick(COFF - 1);
    chk("R9", "collision held", col_o, 1);
    tick();
    chk("R9", "collision released", col_o, 0);
    txe_i = 0;
    for (int k = 1; k <= HD + HL + 1; k++) begin
      tick();
      chk("R8", "heartbeat profile", col_o, hb_exp(k));
    end

    // full duplex
    fdx_i = 1; rx_act_i = 1;
    tick();
    chk("R10", "fdx_o on twisted pair", fdx_o, 1);
    chk("R10", "no loopback in full duplex", loop_en_o, 0);
    txe_i = 1;
    tick(CON + 3);
    chk("R9", "collision masked in full duplex", col_o, 0);
    txe_i = 0;
    for (int k = 1; k <= HD + HL + 1; k++) begin
      tick();
      chk("R9", "heartbeat kept in full duplex", col_o, hb_exp(k));
    end

    // alternate media forces half duplex; collision and heartbeat share the window
    media_mode_i = 2'b00;
    tick();
    chk("R10", "fixed alternate media", utp_sel_o, 0);
    chk("R10", "full duplex dropped", fdx_o, 0);
    chk("R10", "no loopback on alternate media", loop_en_o, 0);
    txe_i = 1;
    tick(CON);
    chk("R9", "collision on alternate media", col_o, 1);
    txe_i = 0;
    for (int k = 1; k <= HD + HL + 1; k++) begin
      tick();
      chk("R11", "collision release then heartbeat", col_o,
          (k <= COFF - 1) ? 1 : hb_exp(k));
    end
    rx_act_i = 0; fdx_i = 0; media_mode_i = 2'b10;

    // R8 cancel
    txe_i = 1; tick(3); txe_i = 0;
    tick(2);
    txe_i = 1; tick(); txe_i = 0;
    any = 0;
    for (int k = 4; k <= 10; k++) begin
      tick();
      if (k <= 7) any |= int'(col_o);
      else chk("R8", "heartbeat from second fall", col_o, 1);
    end
    chk("R8", "cancelled heartbeat stays silent", any, 0);
    tick(3);

    // R8 random lengths
    for (int i = 0; i < 12; i++) begin
      int len;
      len = 1 + int'($urandom % 20);
      txe_i = 1; tick(len); txe_i = 0;
      for (int k = 1; k <= HD + HL + 2; k++) begin
        tick();
        chk("R8", "random heartbeat", col_o, hb_exp(k));
      end
    end

    // R6 / R7 jabber
    txe_i = 1;
    tick(JB - 1);
    chk("R6", "no jabber before limit", tx_block_o, 0);
    chk("R6", "col quiet before limit", col_o, 0);
    tick();
    chk("R6", "jabber blocks", tx_block_o, 1);
    chk("R6", "jabber on col", col_o, 1);
    tick(10);
    txe_i = 0;
    tick(UJ - 1);
    chk("R7", "lockout held", tx_block_o, 1);
    chk("R11", "col held by jabber", col_o, 1);
    tick();
    chk("R7", "lockout released", tx_block_o, 0);
    chk("R11", "col released", col_o, 0);
    any = 0;
    for (int k = 0; k < HD + HL + 2; k++) begin tick(); any |= int'(col_o); end
    chk("R8", "no heartbeat after jabber", any, 0);

    txe_i = 1; tick(JB);
    chk("R6", "second jabber", tx_block_o, 1);
    txe_i = 0; tick(20);
    txe_i = 1; tick(); txe_i = 0;
    tick(UJ - 1);
    chk("R7", "wait restarted by txe", tx_block_o, 1);
    tick();
    chk("R7", "released after restart", tx_block_o, 0);

    // R10 fixed twisted pair with failed link
    tick();
    chk("R4", "link failed after long silence", link_ok_o, 0);
    media_mode_i = 2'b01; tick();
    chk("R10", "fixed twisted pair", utp_sel_o, 1);
    media_mode_i = 2'b11; tick();
    chk("R10", "auto with failed link", utp_sel_o, 0);
    media_mode_i = 2'b10;

    // straps off
    do_reset(1'b0, 1'b0);
    tick(LP - 1);
    chk("R3", "no pulse before period", lp_tx_o, 0);
    tick();
    chk("R2", "pulse emitted without link test", lp_tx_o, 1);
    chk("R1", "link forced despite strap change", link_ok_o, 1);
    chk("R10", "auto selects twisted pair", utp_sel_o, 1);
    tick(LP - 1);
    chk("R3", "no pulse mid period", lp_tx_o, 0);
    tick();
    chk("R3", "periodic pulse", lp_tx_o, 1);
    txe_i = 1;
    any = 0;
    for (int k = 0; k < LP + 10; k++) begin tick(); any |= int'(lp_tx_o); end
    chk("R3", "no pulse during transmit", any, 0);
    txe_i = 0;
    any = 0;
    for (int k = 1; k <= LP; k++) begin
      tick();
      if (k <= HD + HL + 2) any |= int'(col_o);
      if (k == LP - 1) chk("R3", "restart interval", lp_tx_o, 0);
      if (k == LP) chk("R3", "pulse after restart", lp_tx_o, 1);
    end
    chk("R1", "heartbeat off by strap", any, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule